// File: doc/BRIEF.md
# Dual-Edge Interrupt Status Controller

This block gathers up to sixteen synchronous interrupt sources from a peripheral and presents them to a host as one interrupt line plus a readable status word. Each source has its own enable for low-to-high transitions and its own enable for high-to-low transitions. Both may be set, and then either transition is caught. A caught edge sets a sticky status bit. The single interrupt output is high while any status bit is set, and the host is expected to sense that output on its rising edge.

Software reaches the block through a small register bus with a 4-bit address and 16-bit data. One address gives the rising-edge enables and another gives the falling-edge enables. A third address reads back the latched status. A write to that same address loads a clear mask instead of changing the status directly. The mask is held: every bit set in it forces the matching status bit to zero, and it also blocks new edges on that source. Software writes the bits it has serviced and then writes zero to release them. In the default mapping, sources 11 to 15 are the converter-done event, the two touch-panel X-line detectors, the telecom clip detector and the audio clip detector.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, reads of addresses 0x02, 0x03 and 0x04 return zero and `irq_o` is low.
- R2: A write to address 0x02 loads the rising-edge enable word and a write to address 0x03 loads the falling-edge enable word. Bit n of each word belongs to source n, and each word reads back at its own address.
- R3: When source n goes from 0 to 1 and bit n of the rising-edge enable is set, status bit n is 1 in a read of address 0x04 taken after the first clock edge that samples the high level.
- R4: When source n goes from 1 to 0 and bit n of the falling-edge enable is set, status bit n is 1 after the first clock edge that samples the low level.
- R5: When a source has both enables set, either transition sets its status bit. In one pattern, different sources can latch on different edge directions.
- R6: A source with neither enable set never sets its status bit, whatever it does.
- R7: A status bit stays set after its source returns to its earlier level. Only the clear mechanism removes it.
- R8: A write of a nonzero mask to address 0x04 clears the status bits for the set mask bits at that same clock edge. Status bits outside the mask are kept. A later write of zero releases the mask and leaves the remaining status unchanged.
- R9: While a clear-mask bit is held, an edge on that source is dropped. Its status bit reads 0 both during the hold and after the release.
- R10: An enabled edge that arrives in the same cycle as the write of zero to address 0x04 sets its status bit.
- R11: `irq_o` is the OR of the status bits. It goes high after the clock edge that latches the first bit, not before, and it goes low once every bit has been cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register address (0x02 rising enables, 0x03 falling enables, 0x04 status/clear) |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`; zero for unmapped addresses |
| src_i | input | 16 | Synchronous interrupt sources, one bit per source |
| irq_o | output | 1 | Host interrupt, high while any status bit is set |

## Verification
A wrong status register shows at the ports one cycle after the edge that should have set or cleared it. It appears in the read of address 0x04 and in `irq_o` before the next stimulus is applied, so every check samples at the negative edge that follows the deciding clock edge. Faults in the held clear mask only appear while the mask is held or on the release cycle itself. For that reason the hold, the drop and the release race are each checked cycle by cycle, not only after the sequence settles. A stuck previous-value register makes edges appear or vanish in the first cycle after a source changes, and the mixed-direction patterns expose it at once.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

   // register selected by the bus address
   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_RISE,
      SEL_FALL,
      SEL_STAT
   } reg_sel_e;

   // default source assignment
   localparam int SRC_CONV_DONE  = 11;
   localparam int SRC_PANEL_XP   = 12;
   localparam int SRC_PANEL_XM   = 13;
   localparam int SRC_LINE_CLIP  = 14;
   localparam int SRC_SOUND_CLIP = 15;

endpackage

// File: rtl/eirq_cell.sv
module eirq_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic src,
   input  logic rise_en,
   input  logic fall_en,
   input  logic clr,
   output logic stat
);
   logic src_q;
   logic hit;

   assign hit = (rise_en & src & ~src_q) | (fall_en & ~src & src_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q <= 1'b0;
         stat  <= 1'b0;
      end else begin
         src_q <= src;
         stat  <= (stat | hit) & ~clr;
      end
   end
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
   import edge_irq_pkg::*;
#(
   parameter int          NUM_SRC   = 16,
   parameter int          DATA_W    = 16,
   parameter int          ADDR_W    = 4,
   parameter int unsigned RISE_ADDR = 2,
   parameter int unsigned FALL_ADDR = 3,
   parameter int unsigned STAT_ADDR = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               wr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [NUM_SRC-1:0] stat,
   output logic [NUM_SRC-1:0] rise_en,
   output logic [NUM_SRC-1:0] fall_en,
   output logic [NUM_SRC-1:0] clr_eff,
   output logic [DATA_W-1:0]  rdata
);
   localparam int PAD_W = DATA_W - NUM_SRC;

   reg_sel_e           sel;
   logic [NUM_SRC-1:0] clr_q;
   logic [NUM_SRC-1:0] wmask;
   logic [NUM_SRC-1:0] view;

   assign wmask = wdata[NUM_SRC-1:0];

   always_comb begin
      if (addr == ADDR_W'(RISE_ADDR))      sel = SEL_RISE;
      else if (addr == ADDR_W'(FALL_ADDR)) sel = SEL_FALL;
      else if (addr == ADDR_W'(STAT_ADDR)) sel = SEL_STAT;
      else                                 sel = SEL_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rise_en <= '0;
         fall_en <= '0;
         clr_q   <= '0;
      end else if (wr) begin
         case (sel)
            SEL_RISE: rise_en <= wmask;
            SEL_FALL: fall_en <= wmask;
            SEL_STAT: clr_q   <= wmask;
            default:  ;
         endcase
      end
   end

   // a clear write acts in its own cycle, so a release lets a same-cycle edge in
   assign clr_eff = (wr && sel == SEL_STAT) ? wmask : clr_q;

   always_comb begin
      case (sel)
         SEL_RISE: view = rise_en;
         SEL_FALL: view = fall_en;
         SEL_STAT: view = stat;
         default:  view = '0;
      endcase
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign rdata = {{PAD_W{1'b0}}, view};
      end else begin : g_nopad
         assign rdata = view;
      end
   endgenerate
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
   import edge_irq_pkg::*;
#(
   parameter int          NUM_SRC   = 16,
   parameter int          DATA_W    = 16,
   parameter int          ADDR_W    = 4,
   parameter int unsigned RISE_ADDR = 2,
   parameter int unsigned FALL_ADDR = 3,
   parameter int unsigned STAT_ADDR = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [NUM_SRC-1:0] src_i,
   output logic               irq_o
);
   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   generate
      if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
         $error("edge_irq_ctrl: NUM_SRC must be 1..DATA_W");
      end
      if (RISE_ADDR >= ADDR_SPAN || FALL_ADDR >= ADDR_SPAN || STAT_ADDR >= ADDR_SPAN) begin : g_bad_addr
         $error("edge_irq_ctrl: register address outside bus range");
      end
      if (RISE_ADDR == FALL_ADDR || RISE_ADDR == STAT_ADDR || FALL_ADDR == STAT_ADDR) begin : g_dup_addr
         $error("edge_irq_ctrl: register addresses must differ");
      end
   endgenerate

   logic [NUM_SRC-1:0] rise_en;
   logic [NUM_SRC-1:0] fall_en;
   logic [NUM_SRC-1:0] clr_eff;
   logic [NUM_SRC-1:0] stat_q;

   eirq_regs #(
      .NUM_SRC  (NUM_SRC),
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .RISE_ADDR(RISE_ADDR),
      .FALL_ADDR(FALL_ADDR),
      .STAT_ADDR(STAT_ADDR)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (bus_addr),
      .wr     (bus_wr),
      .wdata  (bus_wdata),
      .stat   (stat_q),
      .rise_en(rise_en),
      .fall_en(fall_en),
      .clr_eff(clr_eff),
      .rdata  (bus_rdata)
   );

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         eirq_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .src    (src_i[i]),
            .rise_en(rise_en[i]),
            .fall_en(fall_en[i]),
            .clr    (clr_eff[i]),
            .stat   (stat_q[i])
         );
      end
   endgenerate

   assign irq_o = |stat_q;
endmodule

// File: rtl/eirq_chk.sv
module eirq_chk #(
   parameter int          NUM_SRC   = 16,
   parameter int          DATA_W    = 16,
   parameter int          ADDR_W    = 4,
   parameter int unsigned STAT_ADDR = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic [NUM_SRC-1:0] src_i,
   input logic               irq_o,
   input logic [NUM_SRC-1:0] rise_en,
   input logic [NUM_SRC-1:0] fall_en,
   input logic [NUM_SRC-1:0] clr_eff,
   input logic [NUM_SRC-1:0] stat_q
);
   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
         assert_rise_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (src_i[i] && !$past(src_i[i]) && rise_en[i] && !clr_eff[i]) |=> stat_q[i]);
         assert_fall_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!src_i[i] && $past(src_i[i]) && fall_en[i] && !clr_eff[i]) |=> stat_q[i]);
      end
   endgenerate

   assert_no_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & ~$past(stat_q) & ~($past(rise_en) | $past(fall_en))) == '0));

   assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(stat_q) & ~$past(clr_eff) & ~stat_q) == '0));

   assert_held_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & $past(clr_eff)) == '0));

   assert_irq_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(STAT_ADDR) && bus_rdata != '0) |-> irq_o);
endmodule

bind edge_irq_ctrl eirq_chk #(
   .NUM_SRC  (NUM_SRC),
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .STAT_ADDR(STAT_ADDR)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_rdata(bus_rdata),
   .src_i    (src_i),
   .irq_o    (irq_o),
   .rise_en  (rise_en),
   .fall_en  (fall_en),
   .clr_eff  (clr_eff),
   .stat_q   (stat_q)
);

// File: tb/edge_irq_ctrl_test.sv
`timescale 1ns/1ps
module edge_irq_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = 4'h0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = 16'h0;
   logic [15:0] bus_rdata;
   logic [15:0] src_i = 16'h0;
   logic        irq_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   edge_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_i(src_i), .irq_o(irq_o)
   );

   // {rise_en, fall_en, src_before, src_after, expected_status}
   localparam logic [79:0] VEC [8] = '{
      {16'h0001, 16'h0000, 16'h0000, 16'h0001, 16'h0001},  // R3
      {16'h0000, 16'h8000, 16'h8000, 16'h0000, 16'h8000},  // R4
      {16'h0800, 16'h0800, 16'h0800, 16'h0000, 16'h0800},  // R5 fall side
      {16'h3000, 16'h3000, 16'h0000, 16'h3000, 16'h3000},  // R5 rise side
      {16'h00F0, 16'h000F, 16'h000F, 16'h00F0, 16'h00FF},  // R5 mixed
      {16'h00F0, 16'h0F00, 16'h0F0F, 16'h00F0, 16'h0FF0},  // R3 R4 mixed
      {16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 16'h0000},  // R6
      {16'hAAAA, 16'h5555, 16'h0000, 16'hFFFF, 16'hAAAA}   // R3 R6
   };

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic clear_all();
      wr(4'h4, 16'hFFFF);
      wr(4'h4, 16'h0000);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(4'h2, v); check("R1 rise enable", v, 16'h0);
      rd(4'h3, v); check("R1 fall enable", v, 16'h0);
      rd(4'h4, v); check("R1 status", v, 16'h0);
      check("R1 irq", {15'h0, irq_o}, 16'h0);
      @(negedge clk);

      // R2 enable registers
      wr(4'h2, 16'h1234);
      wr(4'h3, 16'hBEEF);
      rd(4'h2, v); check("R2 rise readback", v, 16'h1234);
      rd(4'h3, v); check("R2 fall readback", v, 16'hBEEF);
      @(negedge clk);

      // vector table
      for (int k = 0; k < 8; k++) begin
         src_i = VEC[k][47:32];
         repeat (2) @(negedge clk);
         clear_all();
         wr(4'h2, VEC[k][79:64]);
         wr(4'h3, VEC[k][63:48]);
         src_i = VEC[k][31:16];
         @(negedge clk);
         rd(4'h4, v);
         check($sformatf("R3/R4/R5/R6 vector %0d status", k), v, VEC[k][15:0]);
         check($sformatf("R11 vector %0d irq", k), {15'h0, irq_o}, {15'h0, VEC[k][15:0] != 16'h0});
         @(negedge clk);
      end

      // R7 sticky status
      src_i = 16'h0;
      repeat (2) @(negedge clk);
      wr(4'h3, 16'h0000);
      wr(4'h2, 16'h0001);
      clear_all();
      src_i[0] = 1'b1;
      @(negedge clk);
      src_i[0] = 1'b0;
      repeat (3) @(negedge clk);
      rd(4'h4, v); check("R7 sticky status", v, 16'h0001);
      check("R7 irq held", {15'h0, irq_o}, 16'h1);
      @(negedge clk);

      // R11 irq timing
      clear_all();
      check("R11 irq low after clear", {15'h0, irq_o}, 16'h0);
      src_i[0] = 1'b1;
      #1;
      check("R11 irq not before edge", {15'h0, irq_o}, 16'h0);
      @(negedge clk);
      check("R11 irq after latch", {15'h0, irq_o}, 16'h1);

      // R8 partial clear with held mask
      src_i = 16'h0;
      @(negedge clk);
      clear_all();
      wr(4'h2, 16'h0011);
      src_i = 16'h0011;
      @(negedge clk);
      wr(4'h4, 16'h0001);
      rd(4'h4, v); check("R8 masked clear", v, 16'h0010);
      @(negedge clk);
      wr(4'h4, 16'h0000);
      rd(4'h4, v); check("R8 after release", v, 16'h0010);
      check("R11 irq with one bit", {15'h0, irq_o}, 16'h1);
      @(negedge clk);
      wr(4'h4, 16'h0010);
      wr(4'h4, 16'h0000);
      rd(4'h4, v); check("R8 all cleared", v, 16'h0000);
      check("R11 irq falls", {15'h0, irq_o}, 16'h0);
      @(negedge clk);

      // R9 edge dropped while clear held
      src_i = 16'h0;
      @(negedge clk);
      wr(4'h2, 16'h0004);
      wr(4'h4, 16'h0004);
      src_i[2] = 1'b1;
      @(negedge clk);
      rd(4'h4, v); check("R9 held drop", v, 16'h0000);
      @(negedge clk);
      wr(4'h4, 16'h0000);
      rd(4'h4, v); check("R9 after release", v, 16'h0000);
      check("R9 irq low", {15'h0, irq_o}, 16'h0);
      @(negedge clk);

      // R10 edge in the release cycle
      src_i = 16'h0;
      @(negedge clk);
      wr(4'h2, 16'h0008);
      wr(4'h4, 16'h0008);
      bus_addr  = 4'h4;
      bus_wdata = 16'h0000;
      bus_wr    = 1'b1;
      src_i[3]  = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      rd(4'h4, v); check("R10 release race", v, 16'h0008);
      check("R10 irq", {15'h0, irq_o}, 16'h1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule